// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block gives a debug host register-level access to a peripheral register file through a serial data path driven by test-clock strobes. The host first selects a chain with a small select register. It then moves a 40-bit access word through the access chain. The word holds a data field, a register address and a direction flag. When the update strobe arrives, the block turns the word into a one-cycle write or read request on a simple parallel register bus.

Reads are pipelined by one scan. The data field loaded on capture is the result of the read requested by the previous scan. A host reading a burst therefore sends one extra scan at the end, with a harmless address such as 0, so that a data register whose read has a side effect is not read one time too many. The TAP state machine and the register file sit outside this block: the block sees only the instruction value, the capture, shift and update strobes, and TDI.

Top module: `scan_reg_port`

## Requirements
- R1: The access chain is active only while `instr` equals 4'hC and the chain select value equals 0. With any other instruction or select value, capture, shift and update have no effect on the access chain and never produce a bus request.
- R2: While `instr` equals 4'h2, the 5-bit select chain is in use. Capture loads it with the current select value. Each shift moves it right, with TDI entering bit 4 and bit 0 driving `tdo`. Update copies it into the select value. With any other instruction the select value does not change.
- R3: The access word is 40 bits: bits 31:0 hold data, bits 38:32 hold the address and bit 39 holds the direction. Each shift moves the word right, with TDI entering bit 39 and bit 0 driving `tdo`. The host therefore sends the data LSB first, then the address, then the direction.
- R4: An update with direction 1 raises `bus_wr_en` for exactly the next cycle, with `bus_addr` and `bus_wdata` taken from the address and data fields.
- R5: An update with direction 0 raises `bus_rd_en` for exactly the next cycle, with `bus_addr` taken from the address field. `bus_rdata` is sampled in that cycle.
- R6: Capture on the access chain loads bits 31:0 with the latest read result and clears bits 39:32. The data shifted out in one scan is therefore the read result of the previous scan's address. A burst of N reads followed by one read of address 0 reads the side-effecting register exactly N times.
- R7: A write request leaves the held read result unchanged.
- R8: After reset `tdo` is 0, no bus request is active, the held read result is 0 and the select value is 31.
- R9: While `instr` is neither 4'hC nor 4'h2, `tdo` is 0.
- R10: `bus_wr_en` and `bus_rd_en` are never high together. Either one is high only in the cycle after an update strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 4 | Current instruction value |
| capture_en | input | 1 | Capture strobe for the selected chain |
| shift_en | input | 1 | Shift strobe for the selected chain |
| update_en | input | 1 | Update strobe for the selected chain |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out: bit 0 of the selected chain, else 0 |
| bus_wr_en | output | 1 | One-cycle register write request |
| bus_rd_en | output | 1 | One-cycle register read request |
| bus_addr | output | 7 | Register address of the request |
| bus_wdata | output | 32 | Write data of the request |
| bus_rdata | input | 32 | Read data returned in the read request cycle |

## Verification
The bench goes after the one-scan read pipeline. A design that loaded the read result of the current scan, or did not forward it, would shift out the wrong word and would read the side-effecting register once too often or once too seldom over a burst. The bench scans before any chain is selected and under an unrelated instruction. A design that gated the chain loosely would then raise a stray write. A write placed between a read and its collecting scan checks that a design refreshing the held result on writes would return stale or wrong data. The select chain is scanned twice so that a reversed shift direction or a wrong reset value shows up in the bits shifted back out.

// File: rtl/scan_reg_port_pkg.sv
package scan_reg_port_pkg;

  typedef enum logic [1:0] {
    PATH_NONE = 2'd0,
    PATH_SEL  = 2'd1,
    PATH_ACC  = 2'd2
  } path_e;

endpackage

// File: rtl/sap_sel_chain.sv
module sap_sel_chain #(
  parameter int          SEL_W   = 5,
  parameter logic [4:0]  RST_SEL = 5'h1F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             tdi,
  output logic             so,
  output logic [SEL_W-1:0] sel_q
);

  logic [SEL_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      sel_q <= SEL_W'(RST_SEL);
    end else if (active) begin
      if (capture)
        sr <= sel_q;
      else if (shift)
        sr <= {tdi, sr[SEL_W-1:1]};
      if (update)
        sel_q <= sr;
    end
  end

  assign so = sr[0];

endmodule

// File: rtl/sap_acc_chain.sv
module sap_acc_chain #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  localparam int WORD_W = DATA_W + ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_data,
  output logic              so,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (active) begin
      if (capture)
        sr <= {{(ADDR_W+1){1'b0}}, cap_data};
      else if (shift)
        sr <= {tdi, sr[WORD_W-1:1]};
    end
  end

  assign so   = sr[0];
  assign word = sr;

endmodule

// File: rtl/sap_bus_issue.sv
module sap_bus_issue #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              f_dir,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic [DATA_W-1:0] f_data,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wr_en,
  output logic              bus_rd_en,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] cap_value
);

  logic [DATA_W-1:0] rd_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_wr_en <= 1'b0;
      bus_rd_en <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rd_hold   <= '0;
    end else begin
      bus_wr_en <= 1'b0;
      bus_rd_en <= 1'b0;
      if (fire) begin
        bus_addr  <= f_addr;
        bus_wr_en <= f_dir;
        bus_rd_en <= ~f_dir;
        if (f_dir)
          bus_wdata <= f_data;
      end
      if (bus_rd_en)
        rd_hold <= bus_rdata;
    end
  end

  // a capture in the read cycle itself sees the fresh bus data
  assign cap_value = bus_rd_en ? bus_rdata : rd_hold;

endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
  import scan_reg_port_pkg::*;
#(
  parameter int          IR_W       = 4,
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 7,
  parameter int          SEL_W      = 5,
  parameter logic [3:0]  ACC_IR     = 4'hC,
  parameter logic [3:0]  SEL_IR     = 4'h2,
  parameter logic [4:0]  ACC_CHAIN  = 5'd0,
  parameter logic [4:0]  RST_SEL    = 5'h1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IR_W-1:0]   instr,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              update_en,
  input  logic              tdi,
  output logic              tdo,
  output logic              bus_wr_en,
  output logic              bus_rd_en,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int WORD_W  = DATA_W + ADDR_W + 1;
  localparam int DIR_BIT = WORD_W - 1;

  path_e             path;
  logic [SEL_W-1:0]  sel_q;
  logic              sel_so, acc_so;
  logic [WORD_W-1:0] acc_word;
  logic [DATA_W-1:0] cap_value;

  always_comb begin
    path = PATH_NONE;
    if (instr == IR_W'(SEL_IR))
      path = PATH_SEL;
    else if (instr == IR_W'(ACC_IR) && sel_q == SEL_W'(ACC_CHAIN))
      path = PATH_ACC;
  end

  sap_sel_chain #(.SEL_W(SEL_W), .RST_SEL(RST_SEL)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .active  (path == PATH_SEL),
    .capture (capture_en),
    .shift   (shift_en),
    .update  (update_en),
    .tdi     (tdi),
    .so      (sel_so),
    .sel_q   (sel_q)
  );

  sap_acc_chain #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .active   (path == PATH_ACC),
    .capture  (capture_en),
    .shift    (shift_en),
    .tdi      (tdi),
    .cap_data (cap_value),
    .so       (acc_so),
    .word     (acc_word)
  );

  sap_bus_issue #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .fire      (update_en && path == PATH_ACC),
    .f_dir     (acc_word[DIR_BIT]),
    .f_addr    (acc_word[DATA_W +: ADDR_W]),
    .f_data    (acc_word[DATA_W-1:0]),
    .bus_rdata (bus_rdata),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cap_value (cap_value)
  );

  always_comb begin
    case (path)
      PATH_SEL: tdo = sel_so;
      PATH_ACC: tdo = acc_so;
      default:  tdo = 1'b0;
    endcase
  end

endmodule

// File: rtl/scan_reg_port_chk.sv
module scan_reg_port_chk #(
  parameter int         IR_W      = 4,
  parameter int         SEL_W     = 5,
  parameter logic [3:0] ACC_IR    = 4'hC,
  parameter logic [3:0] SEL_IR    = 4'h2,
  parameter logic [4:0] ACC_CHAIN = 5'd0
) (
  input logic             clk,
  input logic             rst,
  input logic [IR_W-1:0]  instr,
  input logic             update_en,
  input logic [SEL_W-1:0] sel_q,
  input logic             tdo,
  input logic             bus_wr_en,
  input logic             bus_rd_en
);

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr_en && bus_rd_en));

  p_req_after_update_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en || bus_rd_en) |-> $past(update_en));

  p_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en || bus_rd_en) |->
      ($past(instr) == IR_W'(ACC_IR) && $past(sel_q) == SEL_W'(ACC_CHAIN)));

  p_tdo_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (instr != IR_W'(ACC_IR) && instr != IR_W'(SEL_IR)) |-> !tdo);

  p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (instr != IR_W'(SEL_IR)) |=> $stable(sel_q));

endmodule

bind scan_reg_port scan_reg_port_chk #(
  .IR_W(IR_W), .SEL_W(SEL_W), .ACC_IR(ACC_IR), .SEL_IR(SEL_IR), .ACC_CHAIN(ACC_CHAIN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .instr     (instr),
  .update_en (update_en),
  .sel_q     (sel_q),
  .tdo       (tdo),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en)
);

// File: tb/sim_scan_reg_port.sv
`timescale 1ns/1ps
module sim_scan_reg_port;

  localparam logic [31:0] ID_VAL   = 32'h1D0C_0A55;
  localparam logic [31:0] FIFO_RST = 32'd100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  instr = 4'hC;
  logic        capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
  logic        tdo, bus_wr_en, bus_rd_en;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [128];
  logic [31:0] fifo_val;
  int          fifo_reads;
  int          both_high;

  always #10 clk = ~clk;

  scan_reg_port u0 (
    .clk(clk), .rst(rst), .instr(instr), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .tdi(tdi), .tdo(tdo),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // register file model: address 0 is a fixed ID, address 4 advances on every read
  assign bus_rdata = (bus_addr == 7'd0) ? ID_VAL :
                     (bus_addr == 7'd4) ? fifo_val : mem[bus_addr];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) mem[i] <= 32'h0;
      fifo_val   <= FIFO_RST;
      fifo_reads <= 0;
      both_high  <= 0;
    end else begin
      if (bus_wr_en && bus_addr != 7'd0 && bus_addr != 7'd4) mem[bus_addr] <= bus_wdata;
      if (bus_rd_en && bus_addr == 7'd4) begin
        fifo_val   <= fifo_val + 32'd1;
        fifo_reads <= fifo_reads + 1;
      end
      if (bus_wr_en && bus_rd_en) both_high <= both_high + 1;
    end
  end

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access-chain scan; bus outputs are sampled in the cycle after update
  task automatic acc_scan(input logic dir, input logic [6:0] a, input logic [31:0] d,
                          output logic [39:0] got, output logic wr, output logic rd,
                          output logic [6:0] ba, output logic [31:0] bw);
    logic [39:0] vec;
    vec = {dir, a, d};
    @(negedge clk) capture_en = 1'b1;
    @(negedge clk) capture_en = 1'b0;
    shift_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      tdi = vec[k];
      got[k] = tdo;
      @(negedge clk);
    end
    shift_en = 1'b0;
    update_en = 1'b1;
    @(negedge clk) update_en = 1'b0;
    wr = bus_wr_en; rd = bus_rd_en; ba = bus_addr; bw = bus_wdata;
    @(negedge clk);
  endtask

  task automatic sel_scan(input logic [4:0] v, output logic [4:0] got);
    logic [3:0] keep;
    keep = instr;
    @(negedge clk) instr = 4'h2; capture_en = 1'b1;
    @(negedge clk) capture_en = 1'b0;
    shift_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tdi = v[k];
      got[k] = tdo;
      @(negedge clk);
    end
    shift_en = 1'b0;
    update_en = 1'b1;
    @(negedge clk) update_en = 1'b0;
    instr = keep;
    @(negedge clk);
  endtask

  logic [39:0] g;
  logic        w, r;
  logic [6:0]  ba;
  logic [31:0] bw;
  logic [4:0]  gs;

  task automatic t_reset();
    chk("R8 tdo", {39'd0, tdo}, 40'd0);
    chk("R8 no request", {38'd0, bus_wr_en, bus_rd_en}, 40'd0);
  endtask

  task automatic t_unselected();
    acc_scan(1'b1, 7'h11, 32'hDEAD_BEEF, g, w, r, ba, bw);
    chk("R1 unselected shift-out", g, 40'd0);
    chk("R1 unselected no request", {38'd0, w, r}, 40'd0);
  endtask

  task automatic t_select();
    sel_scan(5'd9, gs);
    chk("R8/R2 select reset value", {35'd0, gs}, 40'd31);
    sel_scan(5'd0, gs);
    chk("R2 select shift-out", {35'd0, gs}, 40'd9);
  endtask

  task automatic t_write();
    acc_scan(1'b1, 7'h11, 32'hA5A5_1234, g, w, r, ba, bw);
    chk("R8 held read result zero", g, 40'd0);
    chk("R4 write pulse", {38'd0, w, r}, 40'd2);
    chk("R3/R4 write address", {33'd0, ba}, 40'h11);
    chk("R3/R4 write data", {8'd0, bw}, {8'd0, 32'hA5A5_1234});
    chk("R4 pulse one cycle", {39'd0, bus_wr_en}, 40'd0);
  endtask

  task automatic t_read_pipe();
    acc_scan(1'b0, 7'h11, 32'h0, g, w, r, ba, bw);
    chk("R5 read pulse", {38'd0, w, r}, 40'd1);
    chk("R5 read address", {33'd0, ba}, 40'h11);
    acc_scan(1'b0, 7'h00, 32'h0, g, w, r, ba, bw);
    chk("R6 previous read returned", g, {8'd0, 32'hA5A5_1234});
    acc_scan(1'b0, 7'h00, 32'h0, g, w, r, ba, bw);
    chk("R6 dummy id read", g, {8'd0, ID_VAL});
  endtask

  task automatic t_write_keeps_hold();
    acc_scan(1'b0, 7'h11, 32'h0, g, w, r, ba, bw);
    acc_scan(1'b1, 7'h22, 32'h0BAD_F00D, g, w, r, ba, bw);
    chk("R6 read before write", g, {8'd0, 32'hA5A5_1234});
    acc_scan(1'b0, 7'h22, 32'h0, g, w, r, ba, bw);
    chk("R7 write left held result", g, {8'd0, 32'hA5A5_1234});
    acc_scan(1'b0, 7'h00, 32'h0, g, w, r, ba, bw);
    chk("R7 written value readable", g, {8'd0, 32'h0BAD_F00D});
  endtask

  task automatic t_burst();
    acc_scan(1'b0, 7'h04, 32'h0, g, w, r, ba, bw);
    for (int i = 0; i < 3; i++) begin
      acc_scan((i == 2) ? 1'b0 : 1'b0, (i == 2) ? 7'h00 : 7'h04, 32'h0, g, w, r, ba, bw);
      chk("R6 burst word", g, {8'd0, FIFO_RST + 32'(i)});
    end
    chk("R6 side-effect read count", 40'(fifo_reads), 40'd3);
  endtask

  task automatic t_other_instr();
    logic [39:0] seen;
    seen = '0;
    @(negedge clk) instr = 4'h5;
    @(negedge clk) capture_en = 1'b1;
    @(negedge clk) capture_en = 1'b0; shift_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      tdi = 1'b1;
      seen[k] = tdo;
      @(negedge clk);
    end
    shift_en = 1'b0; update_en = 1'b1;
    @(negedge clk) update_en = 1'b0;
    chk("R9 tdo quiet", seen, 40'd0);
    chk("R1 no request under other instr", {38'd0, bus_wr_en, bus_rd_en}, 40'd0);
    instr = 4'hC;
    @(negedge clk);
    acc_scan(1'b0, 7'h00, 32'h0, g, w, r, ba, bw);
    chk("R1 access chain untouched", g, {8'd0, ID_VAL});
    chk("R10 never both", 40'(both_high), 40'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unselected();
    t_select();
    t_write();
    t_read_pipe();
    t_write_keeps_hold();
    t_burst();
    t_other_instr();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule